// File: doc/BRIEF.md
# Segment Register File with Linear Address Generation

This block keeps the six segment registers of a segmented 32-bit address space, indexed CS=0, SS=1, DS=2, ES=3, FS=4, GS=5. Each register pairs a visible 16-bit selector with a hidden cache entry holding a 32-bit base, a 32-bit byte limit and a one-bit granularity flag. Two kinds of request arrive. A segment load updates one register. A translation turns a segment index and a 32-bit offset into a linear address, or into a fault.

A 2-bit mode input selects the addressing rules. The encodings are 0 for real, 1 for V86, 2 for protected, and 3, which behaves exactly like protected. In real and V86 modes a load writes the selector and sets the base to the selector shifted left by four; the limit and granularity stay as they were. In protected mode a load fetches a descriptor through a request/response port and then writes the whole cache entry. Because the cache survives mode switches, the granularity from an earlier protected load decides whether real-mode addresses wrap at 1 MB or use the full 32 bits.

Loads are handled by a three-state controller:
- ST_IDLE accepts a load.
- ST_FETCH holds the descriptor request until the responder accepts it.
- ST_WAIT waits for the response.

The transitions are:
- ST_IDLE to ST_FETCH on a protected load of a valid index.
- ST_IDLE to ST_IDLE on an idle cycle, a real or V86 load, or a load of an invalid index.
- ST_FETCH to ST_WAIT when the request is accepted.
- ST_WAIT to ST_IDLE when the response arrives.

Top module: `seg_addr_unit`

## Requirements
- R1: Segment index 0..5 selects CS, SS, DS, ES, FS, GS. A translation with index 6 or 7 faults and returns address 0 and selector 0. A load with index 6 or 7 completes the next cycle with ld_fault_o=1 and changes nothing.
- R2: After reset, CS has selector 0xF000, base 0xFFFF0000, limit 0xFFFF and large granularity (1). Every other register has selector 0, base 0, limit 0xFFFF and small granularity (0). ld_ready_o=1, and out_valid_o, dsc_req_valid_o and ld_done_o are 0.
- R3: A load accepted in real or V86 mode issues no descriptor request. It writes selector = value and base = value<<4, leaves limit and granularity unchanged, and pulses ld_done_o with ld_fault_o=0 one cycle later.
- R4: A load accepted in protected mode raises dsc_req_valid_o in the next cycle, with dsc_req_sel_o equal to the loaded value. Both hold until dsc_req_ready_i is sampled high. ld_ready_o stays 0 from acceptance until the load completes, so only one load is outstanding.
- R5: When dsc_rsp_valid_i arrives in ST_WAIT with dsc_rsp_present_i=1, the selector, base, limit and granularity are written and ld_done_o pulses the next cycle. With present=0, ld_done_o and ld_fault_o pulse together and the register keeps its previous contents.
- R6: In modes 2 and 3 a translation returns base + offset (mod 2^32); the selector takes no part in the sum. An offset greater than the cached limit sets out_fault_o, with out_addr_o = 0.
- R7: In V86 mode a translation returns (base + offset) mod 2^20 and never faults for a valid index.
- R8: In real mode a translation returns (base + offset) mod 2^20 when the cached granularity is 0, and (base + offset) mod 2^32 when it is 1. It never faults for a valid index.
- R9: out_valid_o, out_fault_o, out_addr_o and out_sel_o (the selector of the indexed register) appear exactly one cycle after tr_valid_i. out_valid_o is 0 in any cycle that follows a cycle without a request.
- R10: A translation issued in the cycle after a load completes uses the newly written cache contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 real, 1 V86, 2/3 protected |
| ld_valid_i | input | 1 | Segment load request |
| ld_ready_o | output | 1 | Controller can accept a load |
| ld_seg_i | input | 3 | Index of register to load |
| ld_value_i | input | 16 | Selector value to load |
| ld_done_o | output | 1 | Load completed (pulse) |
| ld_fault_o | output | 1 | Completed load failed |
| dsc_req_valid_o | output | 1 | Descriptor request valid |
| dsc_req_ready_i | input | 1 | Descriptor request accepted |
| dsc_req_sel_o | output | 16 | Selector whose descriptor is requested |
| dsc_rsp_valid_i | input | 1 | Descriptor response valid |
| dsc_rsp_present_i | input | 1 | A descriptor exists for the selector |
| dsc_rsp_base_i | input | 32 | Descriptor base |
| dsc_rsp_limit_i | input | 32 | Descriptor byte limit |
| dsc_rsp_gran_i | input | 1 | Descriptor granularity (1 = large) |
| tr_valid_i | input | 1 | Translation request |
| tr_seg_i | input | 3 | Register index used for translation |
| tr_offset_i | input | 32 | Offset to translate |
| out_valid_o | output | 1 | Translation result valid |
| out_fault_o | output | 1 | Translation faulted |
| out_addr_o | output | 32 | Linear address (0 on fault) |
| out_sel_o | output | 16 | Selector of the indexed register |

## Verification
Translation results are registered, so they are due at the first clock edge after the request. The bench drives a request on a falling edge and reads the result on the next falling edge. A real or V86 load completes at the first edge after acceptance. A protected load moves through three states: the bench checks the request at each falling edge while it withholds ready, returns the response in ST_WAIT, and expects ld_done_o on the falling edge after the response edge. Cache effects are observed through translations issued right after each load completes.

// File: rtl/seg_pkg.sv
package seg_pkg;

    parameter int SEG_SEL_W  = 16;
    parameter int SEG_ADDR_W = 32;

    typedef enum logic [1:0] {
        MODE_REAL     = 2'd0,
        MODE_V86      = 2'd1,
        MODE_PROT     = 2'd2,
        MODE_PROT_ALT = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [SEG_SEL_W-1:0]  sel;
        logic [SEG_ADDR_W-1:0] base;
        logic [SEG_ADDR_W-1:0] limit;
        logic                  gran;
    } seg_entry_t;

endpackage

// File: rtl/seg_cache_file.sv
module seg_cache_file
    import seg_pkg::*;
#(
    parameter int                    NUM_SEG     = 6,
    parameter int                    IDX_W       = 3,
    parameter int                    CS_IDX      = 0,
    parameter logic [SEG_SEL_W-1:0]  CS_SEL_RST  = 16'hF000,
    parameter logic [SEG_ADDR_W-1:0] CS_BASE_RST = 32'hFFFF0000,
    parameter logic                  CS_GRAN_RST = 1'b1,
    parameter logic [SEG_ADDR_W-1:0] LIMIT_RST   = 32'h0000FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_full,
    input  seg_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_entry_t       rd_entry,
    output logic             rd_hit
);

    localparam seg_entry_t CS_RST = '{sel: CS_SEL_RST, base: CS_BASE_RST,
                                      limit: LIMIT_RST, gran: CS_GRAN_RST};
    localparam seg_entry_t GEN_RST = '{sel: '0, base: '0,
                                       limit: LIMIT_RST, gran: 1'b0};

    seg_entry_t entries [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam seg_entry_t RST_VAL = (g == CS_IDX) ? CS_RST : GEN_RST;
        seg_entry_t ent_q;
        logic       hit_w;

        assign hit_w = wr_en && (int'(wr_idx) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= RST_VAL;
            end else if (hit_w) begin
                ent_q.sel  <= wr_entry.sel;
                ent_q.base <= wr_entry.base;
                if (wr_full) begin
                    ent_q.limit <= wr_entry.limit;
                    ent_q.gran  <= wr_entry.gran;
                end
            end
        end

        assign entries[g] = ent_q;
    end

    always_comb begin
        rd_entry = '0;
        rd_hit   = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (int'(rd_idx) == i) begin
                rd_entry = entries[i];
                rd_hit   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int IDX_W   = 3,
    parameter int SHIFT   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  ld_valid_i,
    input  logic [IDX_W-1:0]      ld_seg_i,
    input  logic [SEG_SEL_W-1:0]  ld_value_i,
    output logic                  ld_ready_o,
    output logic                  ld_done_o,
    output logic                  ld_fault_o,
    output logic                  dsc_req_valid_o,
    input  logic                  dsc_req_ready_i,
    output logic [SEG_SEL_W-1:0]  dsc_req_sel_o,
    input  logic                  dsc_rsp_valid_i,
    input  logic                  dsc_rsp_present_i,
    input  logic [SEG_ADDR_W-1:0] dsc_rsp_base_i,
    input  logic [SEG_ADDR_W-1:0] dsc_rsp_limit_i,
    input  logic                  dsc_rsp_gran_i,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic                  wr_full,
    output seg_entry_t            wr_entry
);

    localparam int PAD_W = SEG_ADDR_W - SEG_SEL_W - SHIFT;

    ld_state_e            state_q, state_n;
    logic [IDX_W-1:0]     pend_idx_q;
    logic [SEG_SEL_W-1:0] pend_sel_q;
    logic                 done_q, fault_q;
    logic                 done_n, fault_n;
    logic                 seg_ok, is_prot;
    cpu_mode_e            mode;

    assign mode    = cpu_mode_e'(mode_i);
    assign seg_ok  = int'(ld_seg_i) < NUM_SEG;
    assign is_prot = (mode == MODE_PROT) || (mode == MODE_PROT_ALT);

    // state register and pending-load capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_idx_q <= '0;
            pend_sel_q <= '0;
            done_q     <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= done_n;
            fault_q <= fault_n;
            if (state_q == ST_IDLE && ld_valid_i) begin
                pend_idx_q <= ld_seg_i;
                pend_sel_q <= ld_value_i;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (ld_valid_i && seg_ok && is_prot) state_n = ST_FETCH;
            ST_FETCH: if (dsc_req_ready_i)                 state_n = ST_WAIT;
            ST_WAIT:  if (dsc_rsp_valid_i)                 state_n = ST_IDLE;
            default:                                       state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ld_ready_o      = (state_q == ST_IDLE);
        dsc_req_valid_o = (state_q == ST_FETCH);
        dsc_req_sel_o   = pend_sel_q;
        wr_en           = 1'b0;
        wr_idx          = ld_seg_i;
        wr_full         = 1'b0;
        wr_entry.sel    = ld_value_i;
        wr_entry.base   = {{PAD_W{1'b0}}, ld_value_i, {SHIFT{1'b0}}};
        wr_entry.limit  = '0;
        wr_entry.gran   = 1'b0;
        done_n          = 1'b0;
        fault_n         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_valid_i) begin
                    if (!seg_ok) begin
                        done_n  = 1'b1;
                        fault_n = 1'b1;
                    end else if (!is_prot) begin
                        wr_en  = 1'b1;
                        done_n = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
            end
            ST_WAIT: begin
                if (dsc_rsp_valid_i) begin
                    done_n = 1'b1;
                    if (dsc_rsp_present_i) begin
                        wr_en          = 1'b1;
                        wr_idx         = pend_idx_q;
                        wr_full        = 1'b1;
                        wr_entry.sel   = pend_sel_q;
                        wr_entry.base  = dsc_rsp_base_i;
                        wr_entry.limit = dsc_rsp_limit_i;
                        wr_entry.gran  = dsc_rsp_gran_i;
                    end else begin
                        fault_n = 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    assign ld_done_o  = done_q;
    assign ld_fault_o = fault_q;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  tr_valid_i,
    input  logic [SEG_ADDR_W-1:0] tr_offset_i,
    input  seg_entry_t            entry_i,
    input  logic                  hit_i,
    output logic                  out_valid_o,
    output logic                  out_fault_o,
    output logic [SEG_ADDR_W-1:0] out_addr_o,
    output logic [SEG_SEL_W-1:0]  out_sel_o
);

    localparam logic [SEG_ADDR_W-1:0] WIN_MASK =
        {{(SEG_ADDR_W-WIN_W){1'b0}}, {WIN_W{1'b1}}};

    cpu_mode_e             mode;
    logic [SEG_ADDR_W-1:0] sum, addr_n;
    logic                  fault_n;
    logic [SEG_SEL_W-1:0]  sel_n;

    assign mode = cpu_mode_e'(mode_i);

    always_comb begin
        sum     = entry_i.base + tr_offset_i;
        addr_n  = sum;
        fault_n = !hit_i;
        sel_n   = hit_i ? entry_i.sel : '0;
        unique case (mode)
            MODE_REAL: if (!entry_i.gran) addr_n = sum & WIN_MASK;
            MODE_V86:  addr_n = sum & WIN_MASK;
            MODE_PROT, MODE_PROT_ALT:
                if (tr_offset_i > entry_i.limit) fault_n = 1'b1;
            default: addr_n = sum;
        endcase
        if (fault_n) addr_n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_fault_o <= 1'b0;
            out_addr_o  <= '0;
            out_sel_o   <= '0;
        end else begin
            out_valid_o <= tr_valid_i;
            out_fault_o <= tr_valid_i && fault_n;
            if (tr_valid_i) begin
                out_addr_o <= addr_n;
                out_sel_o  <= sel_n;
            end
        end
    end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_pkg::*;
#(
    parameter int          NUM_SEG     = 6,
    parameter int          WIN_W       = 20,
    parameter int          SHIFT       = 4,
    parameter int          CS_IDX      = 0,
    parameter logic [15:0] CS_SEL_RST  = 16'hF000,
    parameter logic [31:0] CS_BASE_RST = 32'hFFFF0000,
    parameter logic [31:0] LIMIT_RST   = 32'h0000FFFF,
    parameter int          IDX_W       = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             ld_valid_i,
    output logic             ld_ready_o,
    input  logic [IDX_W-1:0] ld_seg_i,
    input  logic [15:0]      ld_value_i,
    output logic             ld_done_o,
    output logic             ld_fault_o,
    output logic             dsc_req_valid_o,
    input  logic             dsc_req_ready_i,
    output logic [15:0]      dsc_req_sel_o,
    input  logic             dsc_rsp_valid_i,
    input  logic             dsc_rsp_present_i,
    input  logic [31:0]      dsc_rsp_base_i,
    input  logic [31:0]      dsc_rsp_limit_i,
    input  logic             dsc_rsp_gran_i,
    input  logic             tr_valid_i,
    input  logic [IDX_W-1:0] tr_seg_i,
    input  logic [31:0]      tr_offset_i,
    output logic             out_valid_o,
    output logic             out_fault_o,
    output logic [31:0]      out_addr_o,
    output logic [15:0]      out_sel_o
);

    logic             wr_en, wr_full, rd_hit;
    logic [IDX_W-1:0] wr_idx;
    seg_entry_t       wr_entry, rd_entry;

    seg_load_fsm #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .SHIFT(SHIFT)) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .mode_i            (mode_i),
        .ld_valid_i        (ld_valid_i),
        .ld_seg_i          (ld_seg_i),
        .ld_value_i        (ld_value_i),
        .ld_ready_o        (ld_ready_o),
        .ld_done_o         (ld_done_o),
        .ld_fault_o        (ld_fault_o),
        .dsc_req_valid_o   (dsc_req_valid_o),
        .dsc_req_ready_i   (dsc_req_ready_i),
        .dsc_req_sel_o     (dsc_req_sel_o),
        .dsc_rsp_valid_i   (dsc_rsp_valid_i),
        .dsc_rsp_present_i (dsc_rsp_present_i),
        .dsc_rsp_base_i    (dsc_rsp_base_i),
        .dsc_rsp_limit_i   (dsc_rsp_limit_i),
        .dsc_rsp_gran_i    (dsc_rsp_gran_i),
        .wr_en             (wr_en),
        .wr_idx            (wr_idx),
        .wr_full           (wr_full),
        .wr_entry          (wr_entry)
    );

    seg_cache_file #(
        .NUM_SEG     (NUM_SEG),
        .IDX_W       (IDX_W),
        .CS_IDX      (CS_IDX),
        .CS_SEL_RST  (CS_SEL_RST),
        .CS_BASE_RST (CS_BASE_RST),
        .CS_GRAN_RST (1'b1),
        .LIMIT_RST   (LIMIT_RST)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_full  (wr_full),
        .wr_entry (wr_entry),
        .rd_idx   (tr_seg_i),
        .rd_entry (rd_entry),
        .rd_hit   (rd_hit)
    );

    seg_xlate #(.WIN_W(WIN_W)) u_xlate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .tr_valid_i  (tr_valid_i),
        .tr_offset_i (tr_offset_i),
        .entry_i     (rd_entry),
        .hit_i       (rd_hit),
        .out_valid_o (out_valid_o),
        .out_fault_o (out_fault_o),
        .out_addr_o  (out_addr_o),
        .out_sel_o   (out_sel_o)
    );

endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
    parameter int NUM_SEG = 6,
    parameter int WIN_W   = 20,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             ld_valid_i,
    input logic             ld_ready_o,
    input logic             ld_done_o,
    input logic             ld_fault_o,
    input logic             dsc_req_valid_o,
    input logic             dsc_req_ready_i,
    input logic [15:0]      dsc_req_sel_o,
    input logic             tr_valid_i,
    input logic [IDX_W-1:0] tr_seg_i,
    input logic             out_valid_o,
    input logic             out_fault_o,
    input logic [31:0]      out_addr_o
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_req_valid_o && !dsc_req_ready_i |=> dsc_req_valid_o && $stable(dsc_req_sel_o)); // R4
    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_req_valid_o |-> !ld_ready_o); // R4
    AST_NO_FETCH_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i && ld_ready_o && (mode_i < 2'd2) |=> !dsc_req_valid_o && ld_done_o); // R3
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid_i |=> out_valid_o); // R9
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tr_valid_i |=> !out_valid_o); // R9
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault_o |-> out_addr_o == '0); // R6
    AST_V86_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid_i && mode_i == 2'd1 |=> out_addr_o[31:WIN_W] == '0); // R7
    AST_BAD_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid_i && (int'(tr_seg_i) >= NUM_SEG) |=> out_fault_o); // R1
    AST_LD_FAULT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault_o |-> ld_done_o); // R5

endmodule

bind seg_addr_unit seg_addr_unit_chk #(.NUM_SEG(NUM_SEG), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .ld_valid_i      (ld_valid_i),
    .ld_ready_o      (ld_ready_o),
    .ld_done_o       (ld_done_o),
    .ld_fault_o      (ld_fault_o),
    .dsc_req_valid_o (dsc_req_valid_o),
    .dsc_req_ready_i (dsc_req_ready_i),
    .dsc_req_sel_o   (dsc_req_sel_o),
    .tr_valid_i      (tr_valid_i),
    .tr_seg_i        (tr_seg_i),
    .out_valid_o     (out_valid_o),
    .out_fault_o     (out_fault_o),
    .out_addr_o      (out_addr_o)
);

// File: tb/tb_seg_addr_unit.sv
module tb_seg_addr_unit;

    localparam int NV = 10;
    localparam int VW = 86;
    // {mode[2], seg[3], offset[32], fault[1], addr[32], sel[16]} on reset state
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 3'd0, 32'h0000FFF0, 1'b0, 32'hFFFFFFF0, 16'hF000}, // R2 R8 large CS
        {2'd0, 3'd2, 32'h00001234, 1'b0, 32'h00001234, 16'h0000}, // R8
        {2'd0, 3'd3, 32'h00123456, 1'b0, 32'h00023456, 16'h0000}, // R8 small wrap
        {2'd1, 3'd0, 32'h0000FFF0, 1'b0, 32'h000FFFF0, 16'hF000}, // R7
        {2'd2, 3'd0, 32'h0000FFFF, 1'b0, 32'hFFFFFFFF, 16'hF000}, // R6 at limit
        {2'd2, 3'd0, 32'h00010000, 1'b1, 32'h00000000, 16'hF000}, // R6 over limit
        {2'd2, 3'd5, 32'h0000FFFF, 1'b0, 32'h0000FFFF, 16'h0000}, // R6
        {2'd2, 3'd1, 32'h00010000, 1'b1, 32'h00000000, 16'h0000}, // R6
        {2'd0, 3'd6, 32'h00000000, 1'b1, 32'h00000000, 16'h0000}, // R1
        {2'd3, 3'd2, 32'h00000010, 1'b0, 32'h00000010, 16'h0000}  // R6 mode 3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_value = '0;
    logic        ld_done, ld_fault;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [15:0] req_sel;
    logic        rsp_valid = 1'b0;
    logic        rsp_present = 1'b0;
    logic [31:0] rsp_base = '0;
    logic [31:0] rsp_limit = '0;
    logic        rsp_gran = 1'b0;
    logic        tr_valid = 1'b0;
    logic [2:0]  tr_seg = '0;
    logic [31:0] tr_offset = '0;
    logic        out_valid, out_fault;
    logic [31:0] out_addr;
    logic [15:0] out_sel;

    int checks = 0;
    int fails = 0;
    int req_cycles = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    seg_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_seg_i(ld_seg),
        .ld_value_i(ld_value), .ld_done_o(ld_done), .ld_fault_o(ld_fault),
        .dsc_req_valid_o(req_valid), .dsc_req_ready_i(req_ready),
        .dsc_req_sel_o(req_sel), .dsc_rsp_valid_i(rsp_valid),
        .dsc_rsp_present_i(rsp_present), .dsc_rsp_base_i(rsp_base),
        .dsc_rsp_limit_i(rsp_limit), .dsc_rsp_gran_i(rsp_gran),
        .tr_valid_i(tr_valid), .tr_seg_i(tr_seg), .tr_offset_i(tr_offset),
        .out_valid_o(out_valid), .out_fault_o(out_fault),
        .out_addr_o(out_addr), .out_sel_o(out_sel)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (req_valid) req_cycles <= req_cycles + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xlate(input logic [1:0] m, input logic [2:0] s, input logic [31:0] off,
                         input logic ef, input logic [31:0] ea, input logic [15:0] es,
                         input string tag);
        @(negedge clk);
        mode = m; tr_valid = 1'b1; tr_seg = s; tr_offset = off;
        @(negedge clk);
        tr_valid = 1'b0;
        chk({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " fault"}, {31'd0, out_fault}, {31'd0, ef});
        chk({tag, " addr"}, out_addr, ea);
        chk({tag, " sel"}, {16'd0, out_sel}, {16'd0, es});
    endtask

    task automatic real_load(input logic [1:0] m, input logic [2:0] s, input logic [15:0] v,
                             input logic ef, input string tag);
        @(negedge clk);
        mode = m; ld_valid = 1'b1; ld_seg = s; ld_value = v;
        @(negedge clk);
        ld_valid = 1'b0;
        chk({tag, " R3 done"}, {31'd0, ld_done}, 32'd1);
        chk({tag, " fault"}, {31'd0, ld_fault}, {31'd0, ef});
    endtask

    task automatic prot_load(input logic [2:0] s, input logic [15:0] v, input logic pres,
                             input logic [31:0] b, input logic [31:0] l, input logic g,
                             input string tag);
        @(negedge clk);
        mode = 2'd2; ld_valid = 1'b1; ld_seg = s; ld_value = v;
        @(negedge clk);
        ld_valid = 1'b0;
        chk({tag, " R4 req"}, {31'd0, req_valid}, 32'd1);
        chk({tag, " R4 sel"}, {16'd0, req_sel}, {16'd0, v});
        chk({tag, " R4 busy"}, {31'd0, ld_ready}, 32'd0);
        @(negedge clk);
        chk({tag, " R4 hold"}, {15'd0, req_valid, req_sel}, {15'd0, 1'b1, v});
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk({tag, " R4 wait"}, {30'd0, req_valid, ld_ready}, 32'd0);
        rsp_valid = 1'b1; rsp_present = pres; rsp_base = b; rsp_limit = l; rsp_gran = g;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk({tag, " R5 done"}, {30'd0, ld_done, ld_fault}, {30'd0, 1'b1, !pres});
    endtask

    initial begin
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 ready", {31'd0, ld_ready}, 32'd1);
        chk("R2 idle outputs", {29'd0, out_valid, req_valid, ld_done}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            xlate(VEC[i][85:84], VEC[i][83:81], VEC[i][80:49], VEC[i][48],
                  VEC[i][47:16], VEC[i][15:0], $sformatf("vec%0d", i));
        end

        @(negedge clk);
        chk("R9 no request", {31'd0, out_valid}, 32'd0);

        rc = req_cycles;
        real_load(2'd0, 3'd2, 16'h1234, 1'b0, "DS real");
        xlate(2'd0, 3'd2, 32'h10, 1'b0, 32'h00012350, 16'h1234, "R10 DS next");
        real_load(2'd1, 3'd3, 16'hFFFF, 1'b0, "ES v86");
        xlate(2'd1, 3'd3, 32'h20, 1'b0, 32'h00000010, 16'hFFFF, "R7 ES wrap");
        xlate(2'd0, 3'd3, 32'h20, 1'b0, 32'h00000010, 16'hFFFF, "R8 ES wrap");
        chk("R3 no fetch", req_cycles, rc);

        prot_load(3'd4, 16'h0018, 1'b1, 32'h00400000, 32'h0000FFFF, 1'b1, "FS prot");
        xlate(2'd2, 3'd4, 32'h100, 1'b0, 32'h00400100, 16'h0018, "R10 FS");
        xlate(2'd2, 3'd4, 32'hFFFF, 1'b0, 32'h0040FFFF, 16'h0018, "R6 FS limit");
        xlate(2'd2, 3'd4, 32'h10000, 1'b1, 32'h0, 16'h0018, "R6 FS over");

        real_load(2'd0, 3'd4, 16'h0100, 1'b0, "FS real");
        xlate(2'd0, 3'd4, 32'h00200000, 1'b0, 32'h00201000, 16'h0100, "R3 R8 gran kept");
        xlate(2'd2, 3'd4, 32'hFFFF, 1'b0, 32'h00010FFF, 16'h0100, "R3 R6 base only");
        xlate(2'd2, 3'd4, 32'h10000, 1'b1, 32'h0, 16'h0100, "R3 limit kept");

        prot_load(3'd5, 16'h0028, 1'b0, 32'h12345678, 32'hFFFFFFFF, 1'b1, "GS absent");
        xlate(2'd2, 3'd5, 32'hFFFF, 1'b0, 32'h0000FFFF, 16'h0000, "R5 GS unchanged");
        xlate(2'd2, 3'd5, 32'h10000, 1'b1, 32'h0, 16'h0000, "R5 GS limit unchanged");

        prot_load(3'd1, 16'h0030, 1'b1, 32'h00FFFFF0, 32'hFFFFFFFF, 1'b0, "SS prot");
        xlate(2'd2, 3'd1, 32'h20, 1'b0, 32'h01000010, 16'h0030, "R6 SS");
        xlate(2'd0, 3'd1, 32'h20, 1'b0, 32'h00000010, 16'h0030, "R8 SS small");

        real_load(2'd0, 3'd7, 16'h5555, 1'b1, "R1 bad index");
        xlate(2'd0, 3'd7, 32'h0, 1'b1, 32'h0, 16'h0000, "R1 bad xlate");
        xlate(2'd0, 3'd0, 32'hFFF0, 1'b0, 32'hFFFFFFF0, 16'hF000, "R1 CS intact");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule